// File: doc/BRIEF.md
# Six-Level Speed Selector

The block keeps a speed level between 0 and 5 for a display counter. Level 0 means the counter is stopped and level 5 is the fastest setting. Two push-button inputs raise and lower the level. Each button passes through a two-flop synchronizer and a rising-edge detector, so one press moves the level by exactly one step, however long the button is held. A toggle-switch input selects the counting direction.

The block has three outputs. The first is the level as a 3-bit binary code. The second is a 10-bit indicator bar that shows the level in the half belonging to the current direction. The third is a one-cycle tick enable whose rate doubles with each level step. The tick comes from a free-running counter that is masked according to the level.

Top module: `speed_level_fsm`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `level` is 0, `led_bar` is all zeros and `tick` is 0.
- R2: A rising edge on `btn_up` raises `level` by one. The new value appears after the third rising clock edge that follows the button change, and not earlier.
- R3: A rising edge on `btn_dn` lowers `level` by one, with the same three-edge latency.
- R4: A button held high for any number of cycles moves `level` by exactly one step, with no fall-through.
- R5: A press of up at level 5 leaves the level at 5. A press of down at level 0 leaves the level at 0.
- R6: If both buttons rise in the same cycle, the two requests cancel and `level` does not change.
- R7: With `dir_down` = 0, `led_bar[9:5]` is zero. In `led_bar[4:0]`, exactly `level` bits are lit, filling from bit 4 downward. The lit value is ((1<<L)-1)<<(5-L).
- R8: With `dir_down` = 1, `led_bar[4:0]` is zero. In `led_bar[9:5]`, exactly `level` bits are lit, filling from bit 5 upward. The lit value is ((1<<L)-1)<<5. `dir_down` passes through a two-flop synchronizer before it reaches the bar.
- R9: At level 0, `tick` never fires. At level L from 1 to 5, `tick` is high for one cycle in every 2^(DIV_SHIFT-L+1) cycles.
- R10: `level` never exceeds 5 and changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_up | input | 1 | Raise-level button, asynchronous |
| btn_dn | input | 1 | Lower-level button, asynchronous |
| dir_down | input | 1 | Direction switch, 1 = counting down |
| level | output | 3 | Current speed level, 0 to 5 |
| led_bar | output | 10 | Direction-split level indicator |
| tick | output | 1 | Count enable, one cycle wide |

## Verification
A button change reaches `level` on the third rising edge after it: two synchronizer edges, then the state update. A `dir_down` change reaches `led_bar` after two edges. The bench drives all inputs on falling edges. It samples `level` exactly two and three falling edges after a press to pin the latency, and waits three cycles before it samples the bar. The tick rate is measured by counting ticks over a window of 2^(DIV_SHIFT+1) cycles at a stable level. Every period divides that window, so the expected count is exact whatever the phase of the divider counter.

// File: rtl/speed_level_fsm.sv
`timescale 1ns/1ps
module speed_level_fsm #(
  parameter int DIV_SHIFT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_up,
  input  logic       btn_dn,
  input  logic       dir_down,
  output logic [2:0] level,
  output logic [9:0] led_bar,
  output logic       tick
);
  localparam logic [2:0] LVL_MAX = 3'd5;
  localparam int CNT_W = DIV_SHIFT;

  logic [2:0] up_sh, dn_sh;
  logic [1:0] dir_sh;
  logic up_pulse, dn_pulse;
  logic [CNT_W-1:0] div_cnt, div_mask;
  logic [4:0] fill_up, fill_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_sh  <= '0;
      dn_sh  <= '0;
      dir_sh <= '0;
    end else begin
      up_sh  <= {up_sh[1:0], btn_up};
      dn_sh  <= {dn_sh[1:0], btn_dn};
      dir_sh <= {dir_sh[0], dir_down};
    end
  end

  assign up_pulse = up_sh[1] & ~up_sh[2];
  assign dn_pulse = dn_sh[1] & ~dn_sh[2];

  always_ff @(posedge clk) begin
    if (!rst_n)
      level <= '0;
    else if (up_pulse && !dn_pulse && level != LVL_MAX)
      level <= level + 3'd1;
    else if (dn_pulse && !up_pulse && level != 3'd0)
      level <= level - 3'd1;
  end

  assign fill_up = ~(5'b11111 >> level);
  assign fill_dn = ~(5'b11111 << level);
  assign led_bar = dir_sh[1] ? {fill_dn, 5'b00000} : {5'b00000, fill_up};

  always_ff @(posedge clk) begin
    if (!rst_n)
      div_cnt <= '0;
    else
      div_cnt <= div_cnt + 1'b1;
  end

  assign div_mask = (level == 3'd0) ? '0 : ({CNT_W{1'b1}} >> (level - 3'd1));
  assign tick = rst_n && (level != 3'd0) && ((div_cnt & div_mask) == '0);

  a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_MAX);
  a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level) || level == $past(level) + 3'd1 ||
              level == $past(level) - 3'd1));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    up_pulse |=> !up_pulse);
  a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse && dn_pulse) |=> $stable(level));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 3'd0) |-> !tick);
  a_r7_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(led_bar) == 32'(level));
  a_r5_top: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_MAX && up_pulse && !dn_pulse) |=> level == LVL_MAX);
endmodule

// File: tb/speed_level_fsm_tb.sv
`timescale 1ns/1ps
module speed_level_fsm_tb;
  localparam int DIV_SHIFT = 6;
  localparam int WIN = 1 << (DIV_SHIFT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_up = 1'b0, btn_dn = 1'b0, dir_down = 1'b0;
  logic [2:0] level;
  logic [9:0] led_bar;
  logic tick;
  int checks = 0, errors = 0;
  bit done = 0;

  speed_level_fsm #(.DIV_SHIFT(DIV_SHIFT)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_up(btn_up), .btn_dn(btn_dn),
    .dir_down(dir_down), .level(level), .led_bar(led_bar), .tick(tick));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(input logic u, input logic d, input int hold);
    @(negedge clk);
    btn_up = u; btn_dn = d;
    repeat (hold) @(negedge clk);
    btn_up = 0; btn_dn = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int exp_led(input int l, input bit dn);
    return dn ? (((1 << l) - 1) << 5) : (((1 << l) - 1) << (5 - l));
  endfunction

  task automatic tick_check(input int l);
    int n = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (tick) n++;
    end
    chk("R9 tick count", n, (l == 0) ? 0 : WIN / (1 << (DIV_SHIFT - l + 1)));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 level in reset", level, 0);
    chk("R1 led in reset", led_bar, 0);
    chk("R1 tick in reset", tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 level after reset", level, 0);
    chk("R1 tick after reset", tick, 0);
    tick_check(0);

    @(negedge clk);
    btn_up = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not before third edge", level, 0);
    @(negedge clk);
    chk("R2 on third edge", level, 1);
    btn_up = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 led up L1", led_bar, exp_led(1, 0));
    tick_check(1);

    for (int l = 2; l <= 5; l++) begin
      press(1, 0, 2);
      chk("R2 step up", level, l);
      chk("R7 led up", led_bar, exp_led(l, 0));
      tick_check(l);
    end
    press(1, 0, 2);
    chk("R5 saturate at 5", level, 5);
    press(0, 1, 40);
    chk("R4 held down one step", level, 4);
    press(1, 0, 40);
    chk("R4 held up one step", level, 5);
    press(0, 1, 2);
    press(1, 1, 4);
    chk("R6 both cancel", level, 4);

    @(negedge clk);
    dir_down = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 led down L4", led_bar, exp_led(4, 1));
    for (int l = 3; l >= 0; l--) begin
      press(0, 1, 2);
      chk("R3 step down", level, l);
      chk("R8 led down", led_bar, exp_led(l, 1));
    end
    press(0, 1, 2);
    chk("R5 saturate at 0", level, 0);
    tick_check(0);
    press(1, 0, 2);
    chk("R8 led down L1", led_bar, exp_led(1, 1));
    @(negedge clk);
    dir_down = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 led back to up half", led_bar, exp_led(1, 0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule